// File: doc/BRIEF.md
# JTAG Scan Command Engine

This block lets a processor drive a JTAG scan chain by writing a packed stream of command bytes. The stream enters a byte-wide write FIFO through one of three push addresses, which take 1, 2 or 4 bytes. A decoder pops one byte per cycle. Each command either walks TMS through a short sequence or shifts up to 128 bits out on TDI. A shifter generates TCK at half the system clock. When capture is requested, it samples TDO on every rising TCK edge and packs the bits into 32-bit words. Those words go into a capture FIFO that the processor reads back.

Software reads a status word and waits for it to become zero, meaning the engine has stopped shifting and the write FIFO is empty. A chain-enable register selects at most one downstream scan chain or port.

The register address map is:

| Address | Access | Use |
|---------|--------|-----|
| 0 | read | status |
| 1 | read and write | chain enable |
| 2 | write | 1-byte push |
| 3 | write | 2-byte push |
| 4 | write | 4-byte push |
| 4 | read | capture-FIFO pop |

Top module: `jtag_scan_engine`

## Requirements
- R1: After a synchronous reset, `tck`, `tms`, `tdi` and `chain_en` are 0, and the status and chain-enable reads return 0.
- R2: Writes to addresses 2, 3 and 4 enqueue 1, 2 or 4 bytes of `wr_data`, lowest byte first. Status bits 30:28 give the write-FIFO byte count, saturated at 7.
- R3: A command byte with bit 7 = 0 is a TMS walk. The highest set bit of bits 5:0 marks the length, and the bits below it are driven on TMS LSB first, one per TCK rise, with TDI at 0. Bit 6 has no effect, and an argument of 0 or 1 produces no TCK.
- R4: A command byte with bit 7 = 1 is a shift, followed by a byte whose bits 6:0 hold L-1 (L from 1 to 128). The engine shifts L bits on TDI LSB first. TMS is 0 on every bit except the last, where it is 1.
- R5: When shift-command bit 4 is set, payload bytes follow. There are 4 bytes for each whole 32 bits of L. For the remainder r = L mod 32, there are 4 more bytes if r > 24, otherwise ceil(r/8) bytes. Bits beyond L are dropped. When bit 4 is clear, L zeros are shifted and no payload bytes are consumed.
- R6: When shift-command bit 2 is set, TDO is sampled at each TCK rise and packed LSB first into 32-bit words. The last word is zero-padded. Reads of address 4 pop these words in order, and a read of an empty capture FIFO returns 0. When bit 2 is clear, nothing is captured.
- R7: TCK is high for exactly one system clock per bit and low for one. TDI and TMS change only while TCK is low, and TCK is low when the engine is idle.
- R8: Status bit 31 is 1 from the cycle after a command's first byte is popped until the last TCK rise of that command is complete. It is 0 whenever the engine is idle.
- R9: A write to address 1 loads the chain-enable register only when the written low `NCH` bits have at most one bit set. Writes with more than one bit set are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| chain_en | output | NCH | One-hot scan-chain enable |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |
| tdo | input | 1 | Test data from the chain |

## Verification
Read data is registered, so the bench samples it on the falling edge one clock after the strobe. The capture monitor compares each popped word against the scoreboard at that same point.

A command's first TCK rise comes three clocks after its final byte is pushed: one clock for the push, one for the decode and one for the low phase. Each bit then takes two clocks. Captured words become readable one clock after the rise that completes them.

The bench does not rely on exact cycle counts for a whole command. It polls the status word until it reads 0, then compares the per-rise TMS/TDI log and the capture words. The status check during a 128-bit shift is made a few clocks after a push, well inside the 256-clock busy window.

// File: rtl/jse_pkg.sv
package jse_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CHAIN  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PUSH8  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PUSH16 = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PUSH32 = 3'd4;

  typedef enum logic [1:0] {
    DEC_IDLE,
    DEC_LEN,
    DEC_LOAD,
    DEC_RUN
  } dec_state_t;
endpackage

// File: rtl/jse_wr_fifo.sv
module jse_wr_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          fits, do_push, do_pop;

  assign fits    = ({1'b0, count} + (CW+1)'(push_n)) <= (CW+1)'(DEPTH);
  assign do_push = push_en && fits;
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  // Storage carries no reset so it maps to plain memory.
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (do_push && (i < int'(push_n)))
        mem[AW'(wptr + AW'(i))] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= AW'(wptr + AW'(push_n));
      if (do_pop)  rptr <= rptr + 1'b1;
      count <= count + (do_push ? CW'(push_n) : '0) - (do_pop ? CW'(1) : '0);
    end
  end
endmodule

// File: rtl/jse_cap_fifo.sv
module jse_cap_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + (do_push ? CW'(1) : '0) - (do_pop ? CW'(1) : '0);
    end
  end
endmodule

// File: rtl/jse_decoder.sv
module jse_decoder
  import jse_pkg::*;
#(
  parameter int MAXB = 128,
  localparam int LW = $clog2(MAXB) + 1,
  localparam int NBW = $clog2(MAXB / 8) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fifo_empty,
  input  logic [7:0]      fifo_head,
  output logic            fifo_pop,
  input  logic            sh_busy,
  output logic            start,
  output logic [MAXB-1:0] st_data,
  output logic [LW-1:0]   st_nbits,
  output logic            st_tms_mode,
  output logic            st_capture,
  output logic            active
);
  dec_state_t      state;
  logic [MAXB-1:0] pay_q, load_word;
  logic [LW-1:0]   nbits_q, len_p1;
  logic            cap_q, pflag_q;
  logic [NBW-1:0]  nbytes_q, bidx_q, nbytes_c;
  logic [2:0]      marker;

  // Position of the highest set bit of the 6-bit TMS argument.
  always_comb begin
    marker = '0;
    for (int i = 0; i < 6; i++)
      if (fifo_head[i]) marker = 3'(i);
  end

  assign len_p1 = LW'(fifo_head[6:0]) + LW'(1);

  // Bytes supplied: whole words, then one word if the rest exceeds 24 bits,
  // otherwise the rest rounded up to bytes.
  always_comb begin
    int words, rest, tail;
    words = int'(len_p1) / 32;
    rest  = int'(len_p1) % 32;
    tail  = (rest > 24) ? 4 : (rest + 7) / 8;
    nbytes_c = NBW'(words * 4 + tail);
  end

  always_comb begin
    load_word = pay_q;
    load_word[{bidx_q, 3'b000} +: 8] = fifo_head;
  end

  always_comb begin
    fifo_pop    = 1'b0;
    start       = 1'b0;
    st_data     = pay_q;
    st_nbits    = nbits_q;
    st_tms_mode = 1'b0;
    st_capture  = cap_q;
    case (state)
      DEC_IDLE: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        if (!fifo_head[7] && (marker != 3'd0)) begin
          start       = 1'b1;
          st_data     = MAXB'(fifo_head[5:0]);
          st_nbits    = LW'(marker);
          st_tms_mode = 1'b1;
          st_capture  = 1'b0;
        end
      end
      DEC_LEN: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        if (!pflag_q) begin
          start    = 1'b1;
          st_data  = '0;
          st_nbits = len_p1;
        end
      end
      DEC_LOAD: if (!fifo_empty) begin
        fifo_pop = 1'b1;
        if (bidx_q == nbytes_q - 1'b1) begin
          start   = 1'b1;
          st_data = load_word;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= DEC_IDLE;
      pay_q    <= '0;
      nbits_q  <= '0;
      cap_q    <= 1'b0;
      pflag_q  <= 1'b0;
      nbytes_q <= '0;
      bidx_q   <= '0;
    end else begin
      case (state)
        DEC_IDLE: if (!fifo_empty) begin
          if (fifo_head[7]) begin
            cap_q   <= fifo_head[2];
            pflag_q <= fifo_head[4];
            state   <= DEC_LEN;
          end else if (marker != 3'd0) begin
            state <= DEC_RUN;
          end
        end
        DEC_LEN: if (!fifo_empty) begin
          nbits_q  <= len_p1;
          nbytes_q <= nbytes_c;
          bidx_q   <= '0;
          pay_q    <= '0;
          state    <= pflag_q ? DEC_LOAD : DEC_RUN;
        end
        DEC_LOAD: if (!fifo_empty) begin
          pay_q  <= load_word;
          bidx_q <= bidx_q + 1'b1;
          if (bidx_q == nbytes_q - 1'b1) state <= DEC_RUN;
        end
        DEC_RUN: if (!sh_busy) state <= DEC_IDLE;
        default: state <= DEC_IDLE;
      endcase
    end
  end

  assign active = (state != DEC_IDLE);
endmodule

// File: rtl/jse_shifter.sv
module jse_shifter #(
  parameter int MAXB = 128,
  localparam int LW = $clog2(MAXB) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MAXB-1:0] st_data,
  input  logic [LW-1:0]   st_nbits,
  input  logic            st_tms_mode,
  input  logic            st_capture,
  input  logic            tdo,
  output logic            tck,
  output logic            tms,
  output logic            tdi,
  output logic            busy,
  output logic            cap_push,
  output logic [31:0]     cap_word
);
  logic [MAXB-1:0] sh;
  logic [LW-1:0]   left;
  logic            ph, tms_mode, cap_en;
  logic [31:0]     capbuf, cap_next;
  logic [4:0]      capn;
  logic            last;

  assign last = (left == LW'(1));

  always_comb begin
    cap_next = capbuf;
    cap_next[capn] = tdo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      left     <= '0;
      ph       <= 1'b0;
      tms_mode <= 1'b0;
      cap_en   <= 1'b0;
      capbuf   <= '0;
      capn     <= '0;
      busy     <= 1'b0;
      tck      <= 1'b0;
      tms      <= 1'b0;
      tdi      <= 1'b0;
      cap_push <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_push <= 1'b0;
      if (!busy) begin
        tck <= 1'b0;
        if (start) begin
          sh       <= st_data;
          left     <= st_nbits;
          tms_mode <= st_tms_mode;
          cap_en   <= st_capture;
          capbuf   <= '0;
          capn     <= '0;
          ph       <= 1'b0;
          busy     <= 1'b1;
        end
      end else if (!ph) begin
        // Low phase: present the next bit.
        tck <= 1'b0;
        tdi <= tms_mode ? 1'b0 : sh[0];
        tms <= tms_mode ? sh[0] : last;
        ph  <= 1'b1;
      end else begin
        // High phase: the chain samples, TDO is captured.
        tck  <= 1'b1;
        ph   <= 1'b0;
        sh   <= sh >> 1;
        left <= left - 1'b1;
        if (cap_en) begin
          if ((capn == 5'd31) || last) begin
            cap_push <= 1'b1;
            cap_word <= cap_next;
            capbuf   <= '0;
            capn     <= '0;
          end else begin
            capbuf <= cap_next;
            capn   <= capn + 1'b1;
          end
        end
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
  import jse_pkg::*;
#(
  parameter int NCH = 8,
  parameter int WF_DEPTH = 16,
  parameter int CAP_DEPTH = 4,
  parameter int MAXB = 128,
  localparam int LW = $clog2(MAXB) + 1,
  localparam int WCW = $clog2(WF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    chain_en,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo
);
  logic            push_en;
  logic [2:0]      push_n;
  logic [7:0]      wf_head;
  logic            wf_empty, wf_pop;
  logic [WCW-1:0]  wf_cnt;
  logic [2:0]      cnt_sat;
  logic            start, st_tms_mode, st_capture, sh_busy, dec_active;
  logic [MAXB-1:0] st_data;
  logic [LW-1:0]   st_nbits;
  logic            cap_push, cap_empty, cap_pop;
  logic [31:0]     cap_word, cap_dout;

  always_comb begin
    push_en = wr_en;
    case (wr_addr)
      ADR_PUSH8:  push_n = 3'd1;
      ADR_PUSH16: push_n = 3'd2;
      ADR_PUSH32: push_n = 3'd4;
      default: begin
        push_n  = 3'd0;
        push_en = 1'b0;
      end
    endcase
  end

  jse_wr_fifo #(.DEPTH(WF_DEPTH)) wf_i (
    .clk(clk), .rst(rst), .push_en(push_en), .push_n(push_n),
    .push_data(wr_data), .pop(wf_pop), .head(wf_head),
    .empty(wf_empty), .count(wf_cnt)
  );

  jse_decoder #(.MAXB(MAXB)) dec_i (
    .clk(clk), .rst(rst), .fifo_empty(wf_empty), .fifo_head(wf_head),
    .fifo_pop(wf_pop), .sh_busy(sh_busy), .start(start), .st_data(st_data),
    .st_nbits(st_nbits), .st_tms_mode(st_tms_mode), .st_capture(st_capture),
    .active(dec_active)
  );

  jse_shifter #(.MAXB(MAXB)) sh_i (
    .clk(clk), .rst(rst), .start(start), .st_data(st_data),
    .st_nbits(st_nbits), .st_tms_mode(st_tms_mode), .st_capture(st_capture),
    .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .busy(sh_busy),
    .cap_push(cap_push), .cap_word(cap_word)
  );

  assign cap_pop = rd_en && (rd_addr == ADR_PUSH32);

  jse_cap_fifo #(.DEPTH(CAP_DEPTH), .W(32)) cap_i (
    .clk(clk), .rst(rst), .push(cap_push), .din(cap_word),
    .pop(cap_pop), .dout(cap_dout), .empty(cap_empty)
  );

  assign cnt_sat = (wf_cnt > WCW'(7)) ? 3'd7 : wf_cnt[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_en <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en && (wr_addr == ADR_CHAIN) && ($countones(wr_data[NCH-1:0]) <= 1))
        chain_en <= wr_data[NCH-1:0];
      if (rd_en) begin
        case (rd_addr)
          ADR_STATUS: rd_data <= {dec_active, cnt_sat, 28'd0};
          ADR_CHAIN:  rd_data <= 32'(chain_en);
          ADR_PUSH32: rd_data <= cap_empty ? 32'd0 : cap_dout;
          default:    rd_data <= 32'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/jse_checker.sv
module jse_checker #(
  parameter int NCH = 8,
  parameter int WF_DEPTH = 16,
  localparam int WCW = $clog2(WF_DEPTH) + 1
) (
  input logic           clk,
  input logic           rst,
  input logic           tck,
  input logic           tms,
  input logic           tdi,
  input logic           active,
  input logic [NCH-1:0] chain_en,
  input logic [WCW-1:0] wf_cnt
);
  AST_CHAIN_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(chain_en)); // R9
  AST_TCK_ONE_HIGH: assert property (@(posedge clk) disable iff (rst) tck |=> !tck); // R7
  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst) tck |-> ($stable(tdi) && $stable(tms))); // R7
  AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (rst) !active |-> !tck); // R8
  AST_WFIFO_BOUND: assert property (@(posedge clk) disable iff (rst) wf_cnt <= WCW'(WF_DEPTH)); // R2
endmodule

bind jtag_scan_engine jse_checker #(.NCH(NCH), .WF_DEPTH(WF_DEPTH)) chk_i (
  .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi),
  .active(dec_active), .chain_en(chain_en), .wf_cnt(wf_cnt)
);

// File: tb/jtag_scan_engine_tb_top.sv
module jtag_scan_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  chain_en;
  logic        tck, tms, tdi, tdo;
  logic        tdo_inv = 1'b0;
  logic        mon_pend = 1'b0;

  int checks = 0;
  int failures = 0;
  int nrise = 0;
  logic [255:0] tms_log, tdi_log;
  logic [31:0]  exp_q[$];

  always #2 clk = ~clk;

  assign tdo = tdi ^ tdo_inv;

  jtag_scan_engine dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .chain_en(chain_en),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  always @(posedge tck) begin
    if (nrise < 256) begin
      tms_log[nrise] = tms;
      tdi_log[nrise] = tdi;
    end
    nrise = nrise + 1;
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Monitor: each capture read is compared with the oldest expected word.
  always @(posedge clk) mon_pend <= rd_en && (rd_addr == 3'd4);
  always @(negedge clk) begin
    if (mon_pend) begin
      logic [31:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'd0;
      check(rd_data == e, "R6 capture word", 256'(rd_data), 256'(e));
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      bus_read(3'd0, s);
      if (s == 32'd0) return;
    end
    check(1'b0, "R8 idle timeout", 256'(s), 256'd0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      bus_read(3'd4, d);
    end
  endtask

  task automatic check_log(input string req, input int n, input logic [255:0] etms, input logic [255:0] etdi);
    logic [255:0] m;
    m = (n >= 256) ? '1 : ((256'd1 << n) - 1);
    check(nrise == n, {req, " tck count"}, 256'(nrise), 256'(n));
    check((tms_log & m) == etms, {req, " tms"}, tms_log & m, etms);
    check((tdi_log & m) == etdi, {req, " tdi"}, tdi_log & m, etdi);
  endtask

  // Driver: issues a shift command, queues the expected capture words,
  // waits for idle and checks the pin log.
  task automatic shift_cmd(input logic [7:0] cmd, input int len, input logic [127:0] pay, input bit inv);
    logic [127:0] bits, m;
    int words, rest;
    tdo_inv = inv;
    nrise = 0;
    m = (len >= 128) ? '1 : ((128'd1 << len) - 1);
    bits = cmd[4] ? (pay & m) : '0;
    bus_write(3'd3, {16'd0, 8'(len - 1), cmd});
    if (cmd[4]) begin
      words = len / 32;
      rest = len % 32;
      for (int w = 0; w < words; w++) bus_write(3'd4, pay[32*w +: 32]);
      if (rest > 24) bus_write(3'd4, pay[32*words +: 32]);
      else for (int j = 0; j < rest; j += 8) bus_write(3'd2, {24'd0, pay[32*words + j +: 8]});
    end
    if (cmd[2]) begin
      logic [127:0] cb;
      cb = (bits ^ (inv ? '1 : '0)) & m;
      for (int w = 0; w < (len + 31) / 32; w++) exp_q.push_back(cb[32*w +: 32]);
    end
    wait_idle();
    check_log("R4 shift", len, 256'(1) << (len - 1), 256'(bits));
  endtask

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(tck == 1'b0 && tms == 1'b0 && tdi == 1'b0, "R1 pins", {tck, tms, tdi}, 0);
    check(chain_en == 8'd0, "R1 chain_en", 256'(chain_en), 0);
    bus_read(3'd0, d);
    check(d == 32'd0, "R1 status", 256'(d), 0);
    bus_read(3'd1, d);
    check(d == 32'd0, "R1 enable", 256'(d), 0);

    // R9 chain enable
    bus_write(3'd1, 32'h80);
    bus_read(3'd1, d);
    check(d == 32'h80 && chain_en == 8'h80, "R9 one-hot load", 256'(d), 256'h80);
    bus_write(3'd1, 32'h03);
    bus_read(3'd1, d);
    check(d == 32'h80, "R9 multi-bit ignored", 256'(d), 256'h80);
    bus_write(3'd1, 32'h0);
    bus_read(3'd1, d);
    check(d == 32'h0, "R9 clear", 256'(d), 0);

    // R3 TMS walk: 0x3F -> five ones
    nrise = 0;
    bus_write(3'd2, 32'h3F);
    wait_idle();
    check_log("R3 tms 0x3F", 5, 256'h1F, 256'h0);
    // R3 bit 6 has no effect: 0x52 -> 0,1,0,0
    nrise = 0;
    bus_write(3'd2, 32'h52);
    wait_idle();
    check_log("R3 tms 0x52", 4, 256'h2, 256'h0);
    // R2 2-byte push, low byte first: 0x03 then 0x06 -> 1,0,1
    nrise = 0;
    bus_write(3'd3, 32'h0603);
    wait_idle();
    check_log("R2 half order", 3, 256'h5, 256'h0);
    // R2/R3 4-byte push: 0x3F,0x01,0x05,0x00 -> 1,1,1,1,1,1,0
    nrise = 0;
    bus_write(3'd4, 32'h0005_013F);
    wait_idle();
    check_log("R2 R3 word order", 7, 256'h3F, 256'h0);

    // R4 R6 32-bit shift with capture
    shift_cmd(8'h94, 32, 128'hA5C3_0F96, 1'b0);
    drain(1);
    // R5 R6 40 bits: one word plus one byte, inverted TDO
    shift_cmd(8'h94, 40, 128'h5A_1234_5678, 1'b1);
    drain(2);
    // R5 57 bits: remainder above 24 supplied as a full word
    shift_cmd(8'h94, 57, 128'hFFEE_DDCC_8765_4321, 1'b0);
    drain(2);
    nrise = 0;
    bus_write(3'd2, 32'h12);
    wait_idle();
    check_log("R5 byte count after shift", 4, 256'h2, 256'h0);
    // R5 no payload: zeros shifted, inverted capture gives ones
    shift_cmd(8'h84, 10, 128'h0, 1'b1);
    drain(1);
    // R6 capture disabled: capture FIFO stays empty
    shift_cmd(8'h90, 8, 128'hC7, 1'b0);
    drain(1);
    // R4 R6 full 128-bit shift
    shift_cmd(8'h94, 128, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0);
    drain(4);
    drain(1);

    // R8 R2 status while busy: 128 zero bits then 4 no-op bytes queued
    tdo_inv = 1'b0;
    nrise = 0;
    bus_write(3'd3, 32'h7F80);
    bus_write(3'd4, 32'h0101_0101);
    bus_read(3'd0, d);
    check(d == 32'hC000_0000, "R8 R2 busy status", 256'(d), 256'hC000_0000);
    wait_idle();
    bus_read(3'd0, d);
    check(d == 32'd0, "R8 idle status", 256'(d), 0);
    check_log("R5 no-payload 128", 128, 256'(1) << 127, 256'h0);
    check(tck == 1'b0, "R7 idle tck", 256'(tck), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule